// File: doc/BRIEF.md
# Shadow Return-Address Stack

This block keeps a private copy of every return address that the core stores on its architectural stack. When the core performs a call, the same address is written into a dedicated on-chip store. No load, store or memory-management path leads to that store. When the core returns, it presents the address it popped from ordinary memory. The block compares that address with its own top entry and pops the entry in the same cycle. If the two differ, the block raises a one-cycle mismatch pulse. With the pulse it presents both the untrusted address and the trusted one, so recovery logic elsewhere could resume at the correct location.

Checking is switched on only by a hardware strap input, which is tied at board or package level. No software-writable setting reaches it. The depth is a parameter. Calls beyond the full depth are counted rather than stored, and the matching returns pass unchecked. A return with nothing recorded is flagged as underflow. A call and a return in the same cycle replace the top entry.

Top module: `shadow_ret_stack`

## Requirements
- R1: A return whose address equals the most recently recorded, not yet returned call address produces no mismatch (last-in, first-out order).
- R2: A return whose address differs from the top entry drives `mismatch_o` high for exactly the one cycle after the return edge. In that cycle `arch_addr_o` holds the returned address and `trusted_addr_o` holds the recorded address.
- R3: A call made while DEPTH entries are held is not stored and sets `overflow_o`, which stays high until reset. The returns that match such unstored calls are not compared. Later returns are compared again against the stored entries.
- R4: A return while no entry is held and no unstored calls are pending sets `underflow_o`, which stays high until reset, and raises no mismatch.
- R5: A call and a return in the same cycle compare the return address against the top entry and then overwrite the top entry with the call address. The depth is unchanged, except on an empty stack, where underflow is set and the call address becomes the only entry.
- R6: While `strap_en_i` is low, calls and returns are ignored. Nothing is written, nothing is popped, no mismatch is raised and no flag changes.
- R7: Reset empties the stack and clears `mismatch_o`, `overflow_o` and `underflow_o`.
- R8: A return that mismatches still pops the entry, so the following return is compared against the entry below it.
- R9: Exactly DEPTH calls can be held without setting `overflow_o`. Call number DEPTH+1 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strap_en_i | input | 1 | Hardware strap enabling the block |
| call_i | input | 1 | Call strobe for one cycle |
| call_addr_i | input | ADDR_W | Return address stored by the call |
| ret_i | input | 1 | Return strobe for one cycle |
| ret_addr_i | input | ADDR_W | Return address popped from the architectural stack |
| mismatch_o | output | 1 | One-cycle stack-corruption pulse |
| arch_addr_o | output | ADDR_W | Last returned (untrusted) address that was compared |
| trusted_addr_o | output | ADDR_W | Recorded address for the last compared return |
| overflow_o | output | 1 | Sticky: a call arrived while full |
| underflow_o | output | 1 | Sticky: a return arrived while empty |

## Verification
The bench goes after a few specific corner cases.

- **Pop on mismatch.** A mismatching return is followed by a return on a now-empty stack. If the design skipped the pop on mismatch, that second return would compare against a stale entry instead of flagging underflow.
- **Same-cycle call and return.** Two same-cycle pairs are followed by plain returns. A design that pushed or popped on such a cycle, instead of replacing the top entry, would compare those returns against the wrong entry or report underflow too early.
- **Calls past full.** The stack is filled exactly to DEPTH and then one call further. A design that lost track of the unstored call would flag the first return after it, or would fail to resume checking on the return after that.
- **Strap low.** A call and a bad return are issued with the strap low. A design that honoured them would raise a mismatch or shift the stack, and later returns would then compare against the wrong entries.

// File: rtl/srs_pkg.sv
package srs_pkg;
   // Per-cycle action chosen by the controller
   typedef enum logic [2:0] {
      OP_IDLE,       // nothing to do
      OP_PUSH,       // store call address
      OP_POP,        // compare and remove top
      OP_REPL,       // compare top, then overwrite it
      OP_SPILL,      // call past full: count only
      OP_UNSPILL,    // return of an unstored call: no compare
      OP_UNDER,      // return on empty stack
      OP_UNDER_PUSH  // call+return on empty stack
   } srs_op_e;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int LOST_W = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             call_i,
   input  logic             ret_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic [PTR_W-1:0] rd_idx_o,
   output logic             chk_o,
   output logic             ovf_o,
   output logic             unf_o
);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);
   localparam logic [LOST_W-1:0] LOST_MAX = '1;

   logic [CNT_W-1:0]  cnt_q;
   logic [LOST_W-1:0] lost_q;
   logic              ovf_q, unf_q;
   srs_op_e           op;
   logic [CNT_W-1:0]  top_cnt;
   logic              full, empty, spilling;

   assign full     = (cnt_q == CNT_FULL);
   assign empty    = (cnt_q == '0);
   assign spilling = (lost_q != '0);
   assign top_cnt  = cnt_q - CNT_W'(1);

   always_comb begin
      op = OP_IDLE;
      if (en_i) begin
         unique case ({call_i, ret_i})
            2'b10:   op = (spilling || full) ? OP_SPILL : OP_PUSH;
            2'b01:   op = spilling ? OP_UNSPILL : (empty ? OP_UNDER : OP_POP);
            2'b11:   op = spilling ? OP_IDLE : (empty ? OP_UNDER_PUSH : OP_REPL);
            default: op = OP_IDLE;
         endcase
      end
   end

   assign rd_idx_o = top_cnt[PTR_W-1:0];
   assign wr_idx_o = (op == OP_REPL) ? top_cnt[PTR_W-1:0] : cnt_q[PTR_W-1:0];
   assign wr_en_o  = (op == OP_PUSH) || (op == OP_REPL) || (op == OP_UNDER_PUSH);
   assign chk_o    = (op == OP_POP) || (op == OP_REPL);
   assign ovf_o    = ovf_q;
   assign unf_o    = unf_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         lost_q <= '0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         unique case (op)
            OP_PUSH:       cnt_q <= cnt_q + CNT_W'(1);
            OP_POP:        cnt_q <= top_cnt;
            OP_UNDER_PUSH: begin
               cnt_q <= CNT_W'(1);
               unf_q <= 1'b1;
            end
            OP_UNDER:      unf_q <= 1'b1;
            OP_SPILL: begin
               ovf_q <= 1'b1;
               if (lost_q != LOST_MAX) lost_q <= lost_q + LOST_W'(1);
            end
            OP_UNSPILL:    lost_q <= lost_q - LOST_W'(1);
            default:       ;
         endcase
      end
   end
endmodule

// File: rtl/srs_mem.sv
module srs_mem #(
   parameter int ADDR_W       = 32,
   parameter int DEPTH        = 32,
   parameter bit CLEAR_ON_RST = 1'b0,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);
   logic [ADDR_W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [ADDR_W-1:0] q;
      logic              hit;
      assign hit = wr_en_i && (wr_idx_i == PTR_W'(g));
      if (CLEAR_ON_RST) begin : g_clr
         always_ff @(posedge clk_i) begin
            if (!rst_ni)  q <= '0;
            else if (hit) q <= wr_data_i;
         end
      end else begin : g_keep
         always_ff @(posedge clk_i) begin
            if (hit) q <= wr_data_i;
         end
      end
      assign slot[g] = q;
   end

   assign rd_data_o = slot[rd_idx_i];
endmodule

// File: rtl/srs_cmp.sv
module srs_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              chk_i,
   input  logic [ADDR_W-1:0] arch_i,
   input  logic [ADDR_W-1:0] shadow_i,
   output logic              mismatch_o,
   output logic [ADDR_W-1:0] arch_o,
   output logic [ADDR_W-1:0] trusted_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mismatch_o <= 1'b0;
         arch_o     <= '0;
         trusted_o  <= '0;
      end else begin
         mismatch_o <= chk_i && (arch_i != shadow_i);
         if (chk_i) begin
            arch_o    <= arch_i;
            trusted_o <= shadow_i;
         end
      end
   end
endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack #(
   parameter int ADDR_W       = 32,
   parameter int DEPTH        = 32,
   parameter int LOST_W       = 16,
   parameter bit CLEAR_ON_RST = 1'b0,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strap_en_i,
   input  logic              call_i,
   input  logic [ADDR_W-1:0] call_addr_i,
   input  logic              ret_i,
   input  logic [ADDR_W-1:0] ret_addr_i,
   output logic              mismatch_o,
   output logic [ADDR_W-1:0] arch_addr_o,
   output logic [ADDR_W-1:0] trusted_addr_o,
   output logic              overflow_o,
   output logic              underflow_o
);
   if (DEPTH < 2)  begin : g_bad_depth  $error("DEPTH must be at least 2");  end
   if (ADDR_W < 1) begin : g_bad_width  $error("ADDR_W must be positive");   end
   if (LOST_W < 1) begin : g_bad_lost   $error("LOST_W must be positive");   end

   logic             wr_en, chk;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [ADDR_W-1:0] top_addr;

   srs_ctrl #(.DEPTH(DEPTH), .LOST_W(LOST_W)) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (strap_en_i),
      .call_i   (call_i),
      .ret_i    (ret_i),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .rd_idx_o (rd_idx),
      .chk_o    (chk),
      .ovf_o    (overflow_o),
      .unf_o    (underflow_o)
   );

   srs_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CLEAR_ON_RST(CLEAR_ON_RST)) u_mem (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (call_addr_i),
      .rd_idx_i  (rd_idx),
      .rd_data_o (top_addr)
   );

   srs_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .chk_i      (chk),
      .arch_i     (ret_addr_i),
      .shadow_i   (top_addr),
      .mismatch_o (mismatch_o),
      .arch_o     (arch_addr_o),
      .trusted_o  (trusted_addr_o)
   );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              strap_en_i,
   input logic              ret_i,
   input logic              mismatch_o,
   input logic [ADDR_W-1:0] arch_addr_o,
   input logic [ADDR_W-1:0] trusted_addr_o,
   input logic              overflow_o,
   input logic              underflow_o
);
   p_mismatch_needs_ret_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mismatch_o |-> $past(ret_i));

   p_mismatch_addrs_differ_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mismatch_o |-> (arch_addr_o != trusted_addr_o));

   p_mismatch_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mismatch_o && !$past(ret_i) |=> 1'b0);

   p_sticky_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o |=> overflow_o);

   p_sticky_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underflow_o |=> underflow_o);

   p_no_mismatch_on_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(underflow_o) |-> !mismatch_o);

   p_strap_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mismatch_o |-> $past(strap_en_i));

   p_strap_flags_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strap_en_i |=> $stable(overflow_o) && $stable(underflow_o));
endmodule

bind shadow_ret_stack srs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_shadow_ret_stack.sv
module test_shadow_ret_stack;
   localparam int AW = 32;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap = 1'b1;
   logic          call = 1'b0, ret = 1'b0;
   logic [AW-1:0] caddr = '0, raddr = '0;
   logic          mm, ovf, unf;
   logic [AW-1:0] arch, trust;
   int            n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   shadow_ret_stack #(.ADDR_W(AW), .DEPTH(DP)) i_shadow_ret_stack (
      .clk_i(clk), .rst_ni(rst_n), .strap_en_i(strap),
      .call_i(call), .call_addr_i(caddr), .ret_i(ret), .ret_addr_i(raddr),
      .mismatch_o(mm), .arch_addr_o(arch), .trusted_addr_o(trust),
      .overflow_o(ovf), .underflow_o(unf)
   );

   typedef struct packed {
      logic          c;
      logic          r;
      logic [AW-1:0] ca;
      logic [AW-1:0] ra;
      logic          mm;
      logic [AW-1:0] tr;
      logic          ov;
      logic          un;
   } vec_t;

   // R1 R2 R4 R5 R8 walked as one sequence on DEPTH 4
   localparam vec_t VECS [10] = '{
      '{1'b1, 1'b0, 32'h1000, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0}, // R1 push
      '{1'b1, 1'b0, 32'h2000, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0}, // R1 push
      '{1'b0, 1'b1, 32'h0,    32'h2000, 1'b0, 32'h0,    1'b0, 1'b0}, // R1 match
      '{1'b0, 1'b1, 32'h0,    32'h2222, 1'b1, 32'h1000, 1'b0, 1'b0}, // R2 bad
      '{1'b0, 1'b1, 32'h0,    32'h3333, 1'b0, 32'h0,    1'b0, 1'b1}, // R8 R4 empty
      '{1'b1, 1'b0, 32'h4000, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1}, // push
      '{1'b1, 1'b1, 32'h5000, 32'h4000, 1'b0, 32'h0,    1'b0, 1'b1}, // R5 replace ok
      '{1'b1, 1'b1, 32'h6000, 32'h4444, 1'b1, 32'h5000, 1'b0, 1'b1}, // R5 replace bad
      '{1'b0, 1'b1, 32'h0,    32'h6000, 1'b0, 32'h0,    1'b0, 1'b1}, // R5 top replaced
      '{1'b0, 1'b1, 32'h0,    32'h7777, 1'b0, 32'h0,    1'b0, 1'b1}  // R5 depth kept
   };

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a negedge, let one posedge pass, return at the next negedge
   task automatic step(input logic c, input logic [AW-1:0] ca, input logic r, input logic [AW-1:0] ra);
      call = c; caddr = ca; ret = r; raddr = ra;
      @(negedge clk);
      call = 1'b0; ret = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R7 reset mismatch", AW'(mm), 0);
      check("R7 reset overflow", AW'(ovf), 0);
      check("R7 reset underflow", AW'(unf), 0);

      foreach (VECS[i]) begin
         step(VECS[i].c, VECS[i].ca, VECS[i].r, VECS[i].ra);
         check($sformatf("vec %0d mismatch", i), AW'(mm), AW'(VECS[i].mm));
         if (VECS[i].mm) begin
            check($sformatf("vec %0d trusted", i), trust, VECS[i].tr);
            check($sformatf("vec %0d arch", i), arch, VECS[i].ra);
         end
         check($sformatf("vec %0d overflow", i), AW'(ovf), AW'(VECS[i].ov));
         check($sformatf("vec %0d underflow", i), AW'(unf), AW'(VECS[i].un));
      end
      step(1'b0, '0, 1'b0, '0);
      check("R2 pulse ends", AW'(mm), 0);

      // R7 reset clears sticky underflow
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R7 underflow cleared", AW'(unf), 0);

      // R9 exactly DEPTH calls held
      for (int k = 0; k < DP; k++) step(1'b1, AW'(32'h100 + k), 1'b0, '0);
      check("R9 full no overflow", AW'(ovf), 0);
      step(1'b1, 32'h104, 1'b0, '0);
      check("R9 call past full", AW'(ovf), 1);
      step(1'b0, '0, 1'b1, 32'hBAD);
      check("R3 unstored return unchecked", AW'(mm), 0);

      // R6 strap low ignores a bad return and a call
      strap = 1'b0;
      step(1'b0, '0, 1'b1, 32'hBAD);
      check("R6 strap low no mismatch", AW'(mm), 0);
      step(1'b1, 32'h999, 1'b0, '0);
      check("R6 strap low flags", AW'(unf), 0);
      strap = 1'b1;

      step(1'b0, '0, 1'b1, 32'hBAD);
      check("R3 checking resumes", AW'(mm), 1);
      check("R3 trusted top", trust, 32'h103);
      check("R3 overflow sticky", AW'(ovf), 1);
      step(1'b0, '0, 1'b1, 32'h102);
      check("R1 R6 next entry matches", AW'(mm), 0);
      step(1'b0, '0, 1'b1, 32'h101);
      check("R1 lifo", AW'(mm), 0);
      step(1'b0, '0, 1'b1, 32'h100);
      check("R1 bottom entry", AW'(mm), 0);
      check("R4 not empty before", AW'(unf), 0);
      step(1'b0, '0, 1'b1, 32'h100);
      check("R4 now empty", AW'(unf), 1);
      check("R4 no mismatch", AW'(mm), 0);

      finish_run();
   end
endmodule